// File: doc/BRIEF.md
# Runtime-Configurable Trigger Condition Unit

This unit sits beside a piece of user logic and watches it without touching it. Every clock it takes a copy of a set of observed data words and of selector/auxiliary pairs taken from the observed logic's branch conditions. It then tests each copy against a condition written at run time through a simple register write port. When every enabled channel's condition holds, it raises its trigger output for that sample. A capture controller elsewhere uses that output to decide when to keep sample data.

A data channel works in one of two modes. In value mode it matches when its word equals a programmed value. In transition mode it matches only when the word moves from a first programmed value in one sample to a second programmed value in the next. A branch channel matches in one of three ways: when its selector equals a programmed state; when that holds and its auxiliary word also equals a programmed value; or when the selector differs from the state. All conditions can be rewritten while the observed logic keeps running. The observed signals only feed registers inside this unit, so the observed logic's paths gain no extra load in series.

Top module: `trig_unit`

## Requirements
- R1: During reset and on the first clock after reset `trig_out` is 0. Every channel comes out of reset disabled.
- R2: A data channel in value mode (control word bit0 = enable = 1, bit1 = 0) matches when its sampled word equals value A. `trig_out` rises two clock edges after the edge at which the matching input was presented, and not at the first edge.
- R3: A data channel in transition mode (control bit1 = 1) matches only when the previous sample equals value A and the current sample equals value B. Holding B, or reaching B from a word other than A, gives no match.
- R4: A branch channel in mode 0 (control bits[2:1] = 00) matches when its selector equals the programmed state.
- R5: A branch channel in mode 1 (bits[2:1] = 01) matches when its selector equals the state and its auxiliary word equals the programmed auxiliary value.
- R6: A branch channel in mode 2 (bits[2:1] = 10) matches when its selector differs from the programmed state.
- R7: `trig_out` is the AND of the matches of all enabled channels. Disabled channels have no effect, whatever their inputs.
- R8: When no channel is enabled, `trig_out` stays 0.
- R9: A configuration write takes effect on the sample held after the write edge. The trigger edge that immediately follows the write edge still reflects the old setting.
- R10: Register map: data channel i uses addresses 4i (control), 4i+1 (value A) and 4i+2 (value B). Branch channel j uses 4(NUM_DATA+j) (control), +1 (state) and +2 (auxiliary value). Writes to offset 3 or to addresses beyond the last channel change nothing. Branch mode 3 never matches.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared with the observed logic |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | ADDR_W | Configuration register address |
| cfg_wdata | input | CFG_W | Configuration write data |
| obs_data | input | NUM_DATA*DATA_W | Observed data words, channel i at bits [i*DATA_W +: DATA_W] |
| obs_sel | input | NUM_CF*SEL_W | Observed branch selectors, one per branch channel |
| obs_aux | input | NUM_CF*AUX_W | Observed auxiliary words, one per branch channel |
| trig_out | output | 1 | Registered trigger, high for each sample meeting the condition |

## Verification
The checker assumes that the observed inputs are synchronous to `clk` and free of unknown values once reset is released. It also assumes that configuration writes are single-cycle strobes with a defined address and data. The bench meets these assumptions by driving every input from a known value at the falling edge, starting before reset is released. Writes are issued one at a time. Sampling also happens at the falling edge, two edges after each stimulus change, so that the two-register latency of the trigger is checked exactly.

// File: rtl/trig_pkg.sv
// Package trig_pkg
// Shared mode encodings and register-map constants for the trigger unit.
// Assumes the control-word layouts listed in the brief.
package trig_pkg;

    // Data channel comparison modes (control bit1).
    typedef enum logic {
        DM_VALUE = 1'b0,
        DM_EDGE  = 1'b1
    } dmode_t;

    // Branch channel modes (control bits[2:1]).
    typedef enum logic [1:0] {
        CF_IS     = 2'd0,
        CF_IS_AND = 2'd1,
        CF_NOT    = 2'd2,
        CF_OFF    = 2'd3
    } cfmode_t;

    // Each channel owns a block of four addresses.
    localparam int CH_STRIDE = 4;
    localparam logic [1:0] OFS_CTRL = 2'd0;
    localparam logic [1:0] OFS_A    = 2'd1;
    localparam logic [1:0] OFS_B    = 2'd2;

endpackage

// File: rtl/trig_arm.sv
// Module trig_arm
// Tracks how many samples have been taken since reset. cur_valid rises one
// edge after reset is released, when the first sample exists. prev_valid
// rises one edge later, when a previous sample exists as well.
// Assumes synchronous active-low reset.
module trig_arm (
    input  logic clk,
    input  logic rst_n,
    output logic cur_valid,
    output logic prev_valid
);

    // Shift a one in behind reset release.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_valid  <= 1'b0;
            prev_valid <= 1'b0;
        end else begin
            cur_valid  <= 1'b1;
            prev_valid <= cur_valid;
        end
    end

endmodule

// File: rtl/trig_data_chan.sv
// Module trig_data_chan
// One data channel. It holds its own configuration (enable, mode, value A,
// value B) and registers the observed word into a current and a previous
// sample. It reports a match in value mode or in transition mode.
// Assumes CFG_W >= DATA_W and CFG_W >= 2. Data bits above DATA_W in a value
// write are dropped.
module trig_data_chan
    import trig_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int CFG_W  = 8,
    parameter int ADDR_W = 5,
    parameter int BASE   = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [ADDR_W-1:0] cfg_addr,
    input  logic [CFG_W-1:0]  cfg_wdata,
    input  logic [DATA_W-1:0] obs,
    input  logic              cur_valid,
    input  logic              prev_valid,
    output logic              en,
    output logic              is_edge,
    output logic              hit
);

    localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(BASE + int'(OFS_CTRL));
    localparam logic [ADDR_W-1:0] A_VA   = ADDR_W'(BASE + int'(OFS_A));
    localparam logic [ADDR_W-1:0] A_VB   = ADDR_W'(BASE + int'(OFS_B));

    logic              en_q;
    dmode_t            mode_q;
    logic [DATA_W-1:0] val_a_q;
    logic [DATA_W-1:0] val_b_q;
    logic [DATA_W-1:0] cur_q;
    logic [DATA_W-1:0] prev_q;
    logic              unused_cfg_bits;

    assign unused_cfg_bits = ^cfg_wdata;

    // Configuration registers, loaded by address match.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q    <= 1'b0;
            mode_q  <= DM_VALUE;
            val_a_q <= '0;
            val_b_q <= '0;
        end else if (cfg_we) begin
            if (cfg_addr == A_CTRL) begin
                en_q   <= cfg_wdata[0];
                mode_q <= dmode_t'(cfg_wdata[1]);
            end
            if (cfg_addr == A_VA) val_a_q <= cfg_wdata[DATA_W-1:0];
            if (cfg_addr == A_VB) val_b_q <= cfg_wdata[DATA_W-1:0];
        end
    end

    // Sample the observed word and keep one sample of history.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_q  <= '0;
            prev_q <= '0;
        end else begin
            cur_q  <= obs;
            prev_q <= cur_q;
        end
    end

    // Compare the samples against the programmed condition.
    always_comb begin
        hit = 1'b0;
        if (cur_valid) begin
            case (mode_q)
                DM_VALUE: hit = (cur_q == val_a_q);
                DM_EDGE:  hit = prev_valid && (prev_q == val_a_q) && (cur_q == val_b_q);
                default:  hit = 1'b0;
            endcase
        end
    end

    assign en      = en_q;
    assign is_edge = en_q && (mode_q == DM_EDGE);

endmodule

// File: rtl/trig_cf_chan.sv
// Module trig_cf_chan
// One branch-activation channel. It registers the observed selector and
// auxiliary word and reports whether the programmed branch is active: the
// selector equals a state, the selector equals the state and the auxiliary
// word equals a value, or the selector differs from the state.
// Assumes CFG_W >= SEL_W, CFG_W >= AUX_W and CFG_W >= 3.
module trig_cf_chan
    import trig_pkg::*;
#(
    parameter int SEL_W  = 4,
    parameter int AUX_W  = 6,
    parameter int CFG_W  = 8,
    parameter int ADDR_W = 5,
    parameter int BASE   = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [ADDR_W-1:0] cfg_addr,
    input  logic [CFG_W-1:0]  cfg_wdata,
    input  logic [SEL_W-1:0]  sel,
    input  logic [AUX_W-1:0]  aux,
    input  logic              cur_valid,
    output logic              en,
    output logic              hit
);

    localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(BASE + int'(OFS_CTRL));
    localparam logic [ADDR_W-1:0] A_ST   = ADDR_W'(BASE + int'(OFS_A));
    localparam logic [ADDR_W-1:0] A_AUX  = ADDR_W'(BASE + int'(OFS_B));

    logic             en_q;
    cfmode_t          mode_q;
    logic [SEL_W-1:0] state_q;
    logic [AUX_W-1:0] auxv_q;
    logic [SEL_W-1:0] sel_q;
    logic [AUX_W-1:0] aux_q;
    logic             unused_cfg_bits;

    assign unused_cfg_bits = ^cfg_wdata;

    // Configuration registers, loaded by address match.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q    <= 1'b0;
            mode_q  <= CF_IS;
            state_q <= '0;
            auxv_q  <= '0;
        end else if (cfg_we) begin
            if (cfg_addr == A_CTRL) begin
                en_q   <= cfg_wdata[0];
                mode_q <= cfmode_t'(cfg_wdata[2:1]);
            end
            if (cfg_addr == A_ST)  state_q <= cfg_wdata[SEL_W-1:0];
            if (cfg_addr == A_AUX) auxv_q  <= cfg_wdata[AUX_W-1:0];
        end
    end

    // Sample the observed selector and auxiliary word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_q <= '0;
            aux_q <= '0;
        end else begin
            sel_q <= sel;
            aux_q <= aux;
        end
    end

    // Decide whether the programmed branch is active in this sample.
    always_comb begin
        hit = 1'b0;
        if (cur_valid) begin
            case (mode_q)
                CF_IS:     hit = (sel_q == state_q);
                CF_IS_AND: hit = (sel_q == state_q) && (aux_q == auxv_q);
                CF_NOT:    hit = (sel_q != state_q);
                default:   hit = 1'b0;
            endcase
        end
    end

    assign en = en_q;

endmodule

// File: rtl/trig_combine.sv
// Module trig_combine
// ANDs the matches of all enabled channels and registers the result. The
// output is held low when no channel is enabled.
// Assumes en and hit come from the same sample.
module trig_combine #(
    parameter int NCH = 6
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [NCH-1:0] en,
    input  logic [NCH-1:0] hit,
    output logic           trig
);

    logic all_ok;

    // A disabled channel counts as satisfied.
    always_comb begin
        all_ok = 1'b1;
        for (int i = 0; i < NCH; i++) begin
            if (en[i] && !hit[i]) all_ok = 1'b0;
        end
    end

    // Register the combined trigger.
    always_ff @(posedge clk) begin
        if (!rst_n) trig <= 1'b0;
        else        trig <= all_ok && (|en);
    end

endmodule

// File: rtl/trig_unit.sv
// Module trig_unit
// Top of the trigger condition unit. It instantiates the data channels, the
// branch channels, the sample-validity tracker and the combiner. Every
// observed input ends in a register inside this unit.
// Assumes CFG_W covers the widest of DATA_W, SEL_W, AUX_W and 3.
module trig_unit
    import trig_pkg::*;
#(
    parameter  int NUM_DATA = 4,
    parameter  int DATA_W   = 8,
    parameter  int NUM_CF   = 2,
    parameter  int SEL_W    = 4,
    parameter  int AUX_W    = 6,
    parameter  int CFG_W    = 8,
    localparam int NCH      = NUM_DATA + NUM_CF,
    localparam int ADDR_W   = $clog2(CH_STRIDE * NCH)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       cfg_we,
    input  logic [ADDR_W-1:0]          cfg_addr,
    input  logic [CFG_W-1:0]           cfg_wdata,
    input  logic [NUM_DATA*DATA_W-1:0] obs_data,
    input  logic [NUM_CF*SEL_W-1:0]    obs_sel,
    input  logic [NUM_CF*AUX_W-1:0]    obs_aux,
    output logic                       trig_out
);

    logic           cur_valid;
    logic           prev_valid;
    logic [NCH-1:0] en_all;
    logic [NCH-1:0] hit_all;
    logic [NCH-1:0] edge_mask;

    trig_arm u_arm (
        .clk        (clk),
        .rst_n      (rst_n),
        .cur_valid  (cur_valid),
        .prev_valid (prev_valid)
    );

    for (genvar i = 0; i < NUM_DATA; i++) begin : g_data
        trig_data_chan #(
            .DATA_W (DATA_W),
            .CFG_W  (CFG_W),
            .ADDR_W (ADDR_W),
            .BASE   (CH_STRIDE * i)
        ) u_ch (
            .clk        (clk),
            .rst_n      (rst_n),
            .cfg_we     (cfg_we),
            .cfg_addr   (cfg_addr),
            .cfg_wdata  (cfg_wdata),
            .obs        (obs_data[i*DATA_W +: DATA_W]),
            .cur_valid  (cur_valid),
            .prev_valid (prev_valid),
            .en         (en_all[i]),
            .is_edge    (edge_mask[i]),
            .hit        (hit_all[i])
        );
    end

    for (genvar j = 0; j < NUM_CF; j++) begin : g_cf
        trig_cf_chan #(
            .SEL_W  (SEL_W),
            .AUX_W  (AUX_W),
            .CFG_W  (CFG_W),
            .ADDR_W (ADDR_W),
            .BASE   (CH_STRIDE * (NUM_DATA + j))
        ) u_ch (
            .clk       (clk),
            .rst_n     (rst_n),
            .cfg_we    (cfg_we),
            .cfg_addr  (cfg_addr),
            .cfg_wdata (cfg_wdata),
            .sel       (obs_sel[j*SEL_W +: SEL_W]),
            .aux       (obs_aux[j*AUX_W +: AUX_W]),
            .cur_valid (cur_valid),
            .en        (en_all[NUM_DATA+j]),
            .hit       (hit_all[NUM_DATA+j])
        );
        assign edge_mask[NUM_DATA+j] = 1'b0;
    end

    trig_combine #(
        .NCH (NCH)
    ) u_comb (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (en_all),
        .hit   (hit_all),
        .trig  (trig_out)
    );

endmodule

// File: rtl/trig_unit_chk.sv
// Module trig_unit_chk
// Assertion checker bound to trig_unit. It relates the channel outputs to
// the registered trigger.
module trig_unit_chk #(
    parameter int NCH = 6
) (
    input logic           clk,
    input logic           rst_n,
    input logic [NCH-1:0] en_all,
    input logic [NCH-1:0] hit_all,
    input logic [NCH-1:0] edge_mask,
    input logic           prev_valid,
    input logic           trig_out
);

    // R1: trigger is low on the edge after a reset cycle
    a_r1_reset_low: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> !trig_out);

    // R1: trigger never unknown out of reset
    a_r1_known: assert property (@(posedge clk) disable iff (!rst_n)
        !$isunknown(trig_out));

    // R8: no enabled channel means no trigger on the next edge
    a_r8_none_enabled: assert property (@(posedge clk) disable iff (!rst_n)
        (en_all == '0) |=> !trig_out);

    // R7: a trigger implies every enabled channel matched one sample earlier
    a_r7_all_enabled_hit: assert property (@(posedge clk) disable iff (!rst_n)
        trig_out |-> $past(((hit_all | ~en_all) == '1) && (en_all != '0)));

    // R3: an enabled transition channel cannot trigger without a previous sample
    a_r3_edge_needs_history: assert property (@(posedge clk) disable iff (!rst_n)
        ((|(en_all & edge_mask)) && !prev_valid) |=> !trig_out);

endmodule

bind trig_unit trig_unit_chk #(.NCH(NCH)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .en_all     (en_all),
    .hit_all    (hit_all),
    .edge_mask  (edge_mask),
    .prev_valid (prev_valid),
    .trig_out   (trig_out)
);

// File: tb/trig_unit_test.sv
// Directed bench for trig_unit: one task per scenario.
module trig_unit_test;

    localparam int ND = 4;
    localparam int DW = 8;
    localparam int NC = 2;
    localparam int SW = 4;
    localparam int AW = 6;
    localparam int CW = 8;
    localparam int ADW = 5;
    localparam int CF0 = 4 * ND;
    localparam int CF1 = 4 * (ND + 1);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_we = 1'b0;
    logic [ADW-1:0] cfg_addr = '0;
    logic [CW-1:0] cfg_wdata = '0;
    logic [DW-1:0] d [ND];
    logic [SW-1:0] s [NC];
    logic [AW-1:0] a [NC];
    logic [ND*DW-1:0] obs_data;
    logic [NC*SW-1:0] obs_sel;
    logic [NC*AW-1:0] obs_aux;
    logic          trig_out;

    int n_run = 0;
    int n_fail = 0;

    always #4 clk = ~clk;

    always_comb begin
        for (int i = 0; i < ND; i++) obs_data[i*DW +: DW] = d[i];
        for (int j = 0; j < NC; j++) begin
            obs_sel[j*SW +: SW] = s[j];
            obs_aux[j*AW +: AW] = a[j];
        end
    end

    trig_unit uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_addr  (cfg_addr),
        .cfg_wdata (cfg_wdata),
        .obs_data  (obs_data),
        .obs_sel   (obs_sel),
        .obs_aux   (obs_aux),
        .trig_out  (trig_out)
    );

    task automatic chk(input string tag, input logic exp);
        n_run++;
        if (trig_out !== exp) begin
            n_fail++;
            $display("FAIL %s trig_out=%b expected=%b", tag, trig_out, exp);
        end
    endtask

    task automatic wr(input int addr, input int data);
        @(negedge clk);
        cfg_we    = 1'b1;
        cfg_addr  = ADW'(addr);
        cfg_wdata = CW'(data);
        @(negedge clk);
        cfg_we    = 1'b0;
    endtask

    task automatic settle();
        @(negedge clk);
        @(negedge clk);
    endtask

    task automatic t_reset();
        for (int i = 0; i < ND; i++) d[i] = '0;
        for (int j = 0; j < NC; j++) begin s[j] = '0; a[j] = '0; end
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk("R1 during reset", 1'b0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 first edge after reset", 1'b0);
        settle();
        chk("R1 channels disabled after reset", 1'b0);
    endtask

    task automatic t_value();
        wr(1, 8'h5A);
        wr(0, 1);
        d[0] = 8'h5A;
        @(negedge clk);
        chk("R2 not at first edge", 1'b0);
        @(negedge clk);
        chk("R2 value match", 1'b1);
        d[0] = 8'h5B;
        settle();
        chk("R2 value mismatch", 1'b0);
    endtask

    task automatic t_trans();
        wr(1, 8'h10);
        wr(2, 8'h20);
        wr(0, 3);
        d[0] = 8'h10;
        settle();
        chk("R3 no trigger on first value", 1'b0);
        d[0] = 8'h20;
        settle();
        chk("R3 transition A to B", 1'b1);
        @(negedge clk);
        chk("R3 holding B", 1'b0);
        d[0] = 8'h30;
        @(negedge clk);
        d[0] = 8'h20;
        settle();
        chk("R3 B reached from other word", 1'b0);
    endtask

    task automatic t_branch();
        wr(0, 0);
        wr(CF0 + 1, 3);
        wr(CF0 + 2, 6'h26);
        wr(CF0, 1);
        s[0] = 4'd3;
        settle();
        chk("R4 selector equals state", 1'b1);
        s[0] = 4'd4;
        settle();
        chk("R4 selector differs", 1'b0);
        wr(CF0, 3);
        s[0] = 4'd3; a[0] = 6'h26;
        settle();
        chk("R5 state and aux match", 1'b1);
        a[0] = 6'h25;
        settle();
        chk("R5 aux differs", 1'b0);
        wr(CF0, 5);
        s[0] = 4'd4;
        settle();
        chk("R6 selector not state", 1'b1);
        s[0] = 4'd3;
        settle();
        chk("R6 selector equals state", 1'b0);
        wr(CF0, 7);
        s[0] = 4'd4;
        settle();
        chk("R10 branch mode 3 never matches", 1'b0);
        wr(CF0, 0);
    endtask

    task automatic t_and();
        wr(5, 7);
        wr(4, 1);
        wr(CF1 + 1, 2);
        wr(CF1, 1);
        d[1] = 8'd7; s[1] = 4'd2;
        settle();
        chk("R7 both enabled match", 1'b1);
        d[1] = 8'd8;
        settle();
        chk("R7 data channel fails", 1'b0);
        d[1] = 8'd7; s[1] = 4'd5;
        settle();
        chk("R7 branch channel fails", 1'b0);
        s[1] = 4'd2; d[2] = 8'hFF; s[0] = 4'd9;
        settle();
        chk("R7 disabled channels ignored", 1'b1);
    endtask

    task automatic t_reconf();
        d[1] = 8'd9;
        settle();
        chk("R9 old value no match", 1'b0);
        wr(5, 9);
        chk("R9 not yet effective", 1'b0);
        @(negedge clk);
        chk("R9 new value effective", 1'b1);
        wr(7, 0);
        wr(31, 0);
        settle();
        chk("R10 unused addresses change nothing", 1'b1);
    endtask

    task automatic t_none();
        wr(4, 0);
        wr(CF1, 0);
        settle();
        chk("R8 no channel enabled", 1'b0);
        @(negedge clk);
        chk("R8 still low", 1'b0);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        n_run++;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin : main
        t_reset();
        t_value();
        t_trans();
        t_branch();
        t_and();
        t_reconf();
        t_none();
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule